// File: doc/BRIEF.md
# DRAM Bank Timing Enforcer

This block guards a single DRAM bank on behalf of a memory controller. Each cycle the controller presents one requested command: open a row, read, write or close the row. It also gives a row number and a flag that asks for the row to close after the access. The block grants the command only when every spacing rule for the bank is satisfied. A request that is not yet legal stays pending with no grant, and it is granted in the first cycle that all rules hold.

The block keeps the bank state (closed, open, or closing on its own) and the number of the open row. It reports whether the presented row hits the open row. It marks the cycle in which read data is valid and the cycle in which write data is due, each after its own programmable latency. All spacings are cycle counts held in configuration registers. These registers are reloaded only while the bank is closed and no data latency is still counting. A programmed value of zero is stored as one.

Top module: `bank_timing_enforcer`

## Requirements
- R1: After reset the bank is closed, `grant`, `rd_valid`, `wr_due` and `auto_pre` are low, and an open-row request (`req_cmd` = 0) is granted in the first cycle it is presented.
- R2: A granted open-row command (`req_cmd` = 0) opens the bank. From the next cycle `bank_open` is high and `open_row` equals the requested row.
- R3: A read (`req_cmd` = 1) is granted no earlier than `cfg_rcd_rd` cycles after the open-row command was granted. A write (`req_cmd` = 2) is granted no earlier than `cfg_rcd_wr` cycles after it. The two limits are independent.
- R4: `rd_valid` is high for one cycle exactly `cfg_cl` cycles after each granted read. Reads granted on consecutive cycles give `rd_valid` on consecutive cycles.
- R5: `wr_due` is high for one cycle exactly `cfg_cwl` cycles after each granted write.
- R6: `row_hit` is high only while the bank is open and `req_row` equals `open_row`. A read or write to a closed bank or to another row is never granted.
- R7: A close request (`req_cmd` = 3) on an open bank is granted no earlier than `cfg_ras` cycles after the open-row grant, and the bank is closed from the next cycle.
- R8: After the bank closes, an open-row request is granted no earlier than `cfg_rp` cycles after the close.
- R9: A request that breaks a rule is held with `grant` low and is granted in exactly the first cycle in which its rules are met.
- R10: A read or write granted with `req_close` high puts the bank into a closing state. In it `auto_pre` pulses in the first cycle at least `cfg_ras` cycles after the open-row grant, the bank is closed from the next cycle, and the `cfg_rp` spacing then applies.
- R11: `cfg_load` copies all six configuration inputs only while the bank is closed and no read or write latency is pending; otherwise it has no effect. A value of zero is stored as one.
- R12: A close request on an already closed bank is granted at once and does not restart the close-to-open spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, commands sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load the configuration inputs (idle only) |
| cfg_rcd_rd | input | TW | Open-row to read spacing |
| cfg_rcd_wr | input | TW | Open-row to write spacing |
| cfg_ras | input | TW | Open-row to close spacing |
| cfg_rp | input | TW | Close to open-row spacing |
| cfg_cl | input | TW | Read command to data-valid latency |
| cfg_cwl | input | TW | Write command to data-due latency |
| req_valid | input | 1 | A command is requested |
| req_cmd | input | 2 | 0 open row, 1 read, 2 write, 3 close row |
| req_row | input | ROW_W | Target row |
| req_close | input | 1 | Close the row automatically after this access |
| grant | output | 1 | Requested command is legal and issues this cycle |
| row_hit | output | 1 | Bank open and target row equals open row |
| bank_open | output | 1 | Bank holds an open row that accepts accesses |
| open_row | output | ROW_W | Number of the open row |
| auto_pre | output | 1 | Automatic close issues this cycle |
| rd_valid | output | 1 | Read data valid this cycle |
| wr_due | output | 1 | Write data due this cycle |

## Verification
The bench times each first grant against the cycle of the previous grant. It checks the exact cycle, so a design that is off by one in any spacing counter grants one cycle early or late and fails that check. Separate values for the read and write spacings show whether the two are mixed up. Three back-to-back reads catch a latency tracker that keeps only one request in flight, because such a design would drop pulses. Row misses, accesses to a closed bank, an automatic close timed against the open-row grant, and a close on an already closed bank are each probed at the ports. A configuration load attempted while the bank is open must leave the old close spacing in force, and zero values must behave as one.

// File: rtl/bte_pkg.sv
package bte_pkg;

    localparam int unsigned TW = 5;

    typedef logic [TW-1:0] tval_t;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        BK_CLOSED  = 2'd0,
        BK_OPEN    = 2'd1,
        BK_CLOSING = 2'd2
    } bank_e;

    typedef struct packed {
        tval_t rcd_rd;
        tval_t rcd_wr;
        tval_t ras;
        tval_t rp;
        tval_t cl;
        tval_t cwl;
    } timing_t;

    function automatic tval_t at_least_one(tval_t v);
        return (v == '0) ? tval_t'(1) : v;
    endfunction

    function automatic logic reached(tval_t cnt, tval_t lim);
        return cnt >= lim;
    endfunction

endpackage

// File: rtl/bte_cfg_regs.sv
module bte_cfg_regs
    import bte_pkg::*;
#(
    parameter int unsigned DEF_RCD_RD = 4,
    parameter int unsigned DEF_RCD_WR = 2,
    parameter int unsigned DEF_RAS    = 8,
    parameter int unsigned DEF_RP     = 3,
    parameter int unsigned DEF_CL     = 5,
    parameter int unsigned DEF_CWL    = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    load_ok,
    input  timing_t new_cfg,
    output timing_t cfg
);

    timing_t reset_cfg;

    always_comb begin
        reset_cfg.rcd_rd = at_least_one(tval_t'(DEF_RCD_RD));
        reset_cfg.rcd_wr = at_least_one(tval_t'(DEF_RCD_WR));
        reset_cfg.ras    = at_least_one(tval_t'(DEF_RAS));
        reset_cfg.rp     = at_least_one(tval_t'(DEF_RP));
        reset_cfg.cl     = at_least_one(tval_t'(DEF_CL));
        reset_cfg.cwl    = at_least_one(tval_t'(DEF_CWL));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= reset_cfg;
        end else if (load_ok) begin
            cfg.rcd_rd <= at_least_one(new_cfg.rcd_rd);
            cfg.rcd_wr <= at_least_one(new_cfg.rcd_wr);
            cfg.ras    <= at_least_one(new_cfg.ras);
            cfg.rp     <= at_least_one(new_cfg.rp);
            cfg.cl     <= at_least_one(new_cfg.cl);
            cfg.cwl    <= at_least_one(new_cfg.cwl);
        end
    end

endmodule

// File: rtl/bte_elapsed.sv
module bte_elapsed #(
    parameter int unsigned W        = 5,
    parameter bit          RST_FULL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] FULL = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= RST_FULL ? FULL : '0;
        end else if (restart) begin
            count <= W'(1);
        end else if (count != FULL) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/bte_lat_pipe.sv
module bte_lat_pipe #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] lat,
    output logic         fire,
    output logic         busy
);

    localparam int unsigned DEPTH = 2 ** W;

    logic [DEPTH-1:0] stages;

    always_ff @(posedge clk) begin
        if (rst) begin
            stages <= '0;
        end else begin
            stages <= {stages[DEPTH-2:0], push};
        end
    end

    always_comb begin
        fire = stages[lat - W'(1)];
        busy = |stages;
    end

endmodule

// File: rtl/bank_timing_enforcer.sv
module bank_timing_enforcer
    import bte_pkg::*;
#(
    parameter int unsigned ROW_W      = 14,
    parameter int unsigned DEF_RCD_RD = 4,
    parameter int unsigned DEF_RCD_WR = 2,
    parameter int unsigned DEF_RAS    = 8,
    parameter int unsigned DEF_RP     = 3,
    parameter int unsigned DEF_CL     = 5,
    parameter int unsigned DEF_CWL    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [TW-1:0]    cfg_rcd_rd,
    input  logic [TW-1:0]    cfg_rcd_wr,
    input  logic [TW-1:0]    cfg_ras,
    input  logic [TW-1:0]    cfg_rp,
    input  logic [TW-1:0]    cfg_cl,
    input  logic [TW-1:0]    cfg_cwl,
    input  logic             req_valid,
    input  logic [1:0]       req_cmd,
    input  logic [ROW_W-1:0] req_row,
    input  logic             req_close,
    output logic             grant,
    output logic             row_hit,
    output logic             bank_open,
    output logic [ROW_W-1:0] open_row,
    output logic             auto_pre,
    output logic             rd_valid,
    output logic             wr_due
);

    localparam int unsigned NPIPE = 2;
    localparam int unsigned P_RD  = 0;
    localparam int unsigned P_WR  = 1;

    timing_t    tcfg;
    timing_t    cfg_in;
    bank_e      state_q;
    logic [ROW_W-1:0] row_q;
    tval_t      act_cnt;
    tval_t      pre_cnt;
    cmd_e       cmd;
    logic       legal;
    logic       act_fire;
    logic       pre_fire;
    logic       col_fire;
    logic       load_ok;
    logic       idle;
    logic [NPIPE-1:0] pipe_push;
    logic [NPIPE-1:0] pipe_fire;
    logic [NPIPE-1:0] pipe_busy;
    tval_t      pipe_lat [NPIPE];

    // configuration
    always_comb begin
        cfg_in.rcd_rd = cfg_rcd_rd;
        cfg_in.rcd_wr = cfg_rcd_wr;
        cfg_in.ras    = cfg_ras;
        cfg_in.rp     = cfg_rp;
        cfg_in.cl     = cfg_cl;
        cfg_in.cwl    = cfg_cwl;
        idle          = (state_q == BK_CLOSED) && (pipe_busy == '0);
        load_ok       = cfg_load && idle;
    end

    bte_cfg_regs #(
        .DEF_RCD_RD(DEF_RCD_RD),
        .DEF_RCD_WR(DEF_RCD_WR),
        .DEF_RAS   (DEF_RAS),
        .DEF_RP    (DEF_RP),
        .DEF_CL    (DEF_CL),
        .DEF_CWL   (DEF_CWL)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load_ok(load_ok),
        .new_cfg(cfg_in),
        .cfg    (tcfg)
    );

    // cycles since the row was opened, and since it was closed
    bte_elapsed #(.W(TW), .RST_FULL(1'b0)) u_since_act (
        .clk    (clk),
        .rst    (rst),
        .restart(act_fire),
        .count  (act_cnt)
    );

    bte_elapsed #(.W(TW), .RST_FULL(1'b1)) u_since_pre (
        .clk    (clk),
        .rst    (rst),
        .restart(pre_fire),
        .count  (pre_cnt)
    );

    // command legality
    always_comb begin
        cmd     = cmd_e'(req_cmd);
        row_hit = (state_q == BK_OPEN) && (req_row == row_q);
        legal   = 1'b0;
        unique case (cmd)
            CMD_ACT: legal = (state_q == BK_CLOSED) && reached(pre_cnt, tcfg.rp);
            CMD_RD:  legal = row_hit && reached(act_cnt, tcfg.rcd_rd);
            CMD_WR:  legal = row_hit && reached(act_cnt, tcfg.rcd_wr);
            CMD_PRE: legal = (state_q == BK_CLOSED) ||
                             ((state_q == BK_OPEN) && reached(act_cnt, tcfg.ras));
            default: legal = 1'b0;
        endcase
        grant    = req_valid && legal;
        auto_pre = (state_q == BK_CLOSING) && reached(act_cnt, tcfg.ras);
        act_fire = grant && (cmd == CMD_ACT);
        col_fire = grant && ((cmd == CMD_RD) || (cmd == CMD_WR));
        pre_fire = auto_pre || (grant && (cmd == CMD_PRE) && (state_q == BK_OPEN));
    end

    // bank state and open row
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BK_CLOSED;
            row_q   <= '0;
        end else begin
            if (act_fire) begin
                state_q <= BK_OPEN;
                row_q   <= req_row;
            end else if (pre_fire) begin
                state_q <= BK_CLOSED;
            end else if (col_fire && req_close) begin
                state_q <= BK_CLOSING;
            end
        end
    end

    always_comb begin
        bank_open = (state_q == BK_OPEN);
        open_row  = row_q;
    end

    // data latency trackers, one per direction
    always_comb begin
        pipe_push[P_RD] = grant && (cmd == CMD_RD);
        pipe_push[P_WR] = grant && (cmd == CMD_WR);
        pipe_lat[P_RD]  = tcfg.cl;
        pipe_lat[P_WR]  = tcfg.cwl;
    end

    for (genvar gi = 0; gi < NPIPE; gi++) begin : g_pipe
        bte_lat_pipe #(.W(TW)) u_pipe (
            .clk (clk),
            .rst (rst),
            .push(pipe_push[gi]),
            .lat (pipe_lat[gi]),
            .fire(pipe_fire[gi]),
            .busy(pipe_busy[gi])
        );
    end

    always_comb begin
        rd_valid = pipe_fire[P_RD];
        wr_due   = pipe_fire[P_WR];
    end

endmodule

// File: rtl/bte_checker.sv
module bte_checker #(
    parameter int unsigned TW    = 5,
    parameter int unsigned ROW_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [1:0]       req_cmd,
    input logic [ROW_W-1:0] req_row,
    input logic             grant,
    input logic             row_hit,
    input logic             bank_open,
    input logic [ROW_W-1:0] open_row,
    input logic             auto_pre,
    input logic [TW-1:0]    rcd_rd,
    input logic [TW-1:0]    ras
);

    localparam logic [TW:0] SAT = {(TW+1){1'b1}};

    logic [TW:0] since_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= '0;
        end else if (grant && req_cmd == 2'd0) begin
            since_act <= (TW+1)'(1);
        end else if (since_act != SAT) begin
            since_act <= since_act + (TW+1)'(1);
        end
    end

    assert_grant_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
        grant |-> req_valid);

    assert_act_opens_row_R2: assert property (@(posedge clk) disable iff (rst)
        (grant && req_cmd == 2'd0) |=> (bank_open && open_row == $past(req_row)));

    assert_read_after_rcd_R3: assert property (@(posedge clk) disable iff (rst)
        (grant && req_cmd == 2'd1) |-> (since_act >= {1'b0, rcd_rd}));

    assert_column_hits_R6: assert property (@(posedge clk) disable iff (rst)
        (grant && (req_cmd == 2'd1 || req_cmd == 2'd2)) |-> row_hit);

    assert_close_after_ras_R7: assert property (@(posedge clk) disable iff (rst)
        (grant && req_cmd == 2'd3 && bank_open) |-> (since_act >= {1'b0, ras}));

    assert_auto_close_R10: assert property (@(posedge clk) disable iff (rst)
        auto_pre |=> !bank_open);

endmodule

bind bank_timing_enforcer bte_checker #(.TW(bte_pkg::TW), .ROW_W(ROW_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_cmd  (req_cmd),
    .req_row  (req_row),
    .grant    (grant),
    .row_hit  (row_hit),
    .bank_open(bank_open),
    .open_row (open_row),
    .auto_pre (auto_pre),
    .rcd_rd   (tcfg.rcd_rd),
    .ras      (tcfg.ras)
);

// File: tb/bank_timing_enforcer_bench.sv
module bank_timing_enforcer_bench;

    localparam int TW    = 5;
    localparam int ROW_W = 14;

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_load;
    logic [TW-1:0]    cfg_rcd_rd, cfg_rcd_wr, cfg_ras, cfg_rp, cfg_cl, cfg_cwl;
    logic             req_valid;
    logic [1:0]       req_cmd;
    logic [ROW_W-1:0] req_row;
    logic             req_close;
    logic             grant, row_hit, bank_open, auto_pre, rd_valid, wr_due;
    logic [ROW_W-1:0] open_row;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bank_timing_enforcer #(.ROW_W(ROW_W)) u_bank_timing_enforcer (
        .clk(clk), .rst(rst), .cfg_load(cfg_load),
        .cfg_rcd_rd(cfg_rcd_rd), .cfg_rcd_wr(cfg_rcd_wr), .cfg_ras(cfg_ras),
        .cfg_rp(cfg_rp), .cfg_cl(cfg_cl), .cfg_cwl(cfg_cwl),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_row(req_row),
        .req_close(req_close), .grant(grant), .row_hit(row_hit),
        .bank_open(bank_open), .open_row(open_row), .auto_pre(auto_pre),
        .rd_valid(rd_valid), .wr_due(wr_due)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_req(input bit v, input int cmd, input int row, input bit cl);
        req_valid = v;
        req_cmd   = 2'(cmd);
        req_row   = ROW_W'(row);
        req_close = cl;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // present a command, count cycles to grant, let it issue
    task automatic issue(input int cmd, input int row, input bit cl, input int exp,
                         input string req);
        int n;
        set_req(1'b1, cmd, row, cl);
        n = 1;
        forever begin
            #1;
            if (grant || n > 60) break;
            @(negedge clk);
            n++;
        end
        check(n == exp, req, n, exp);
        @(negedge clk);
        set_req(1'b0, 0, 0, 1'b0);
    endtask

    // count cycles until an output pulses (0 rd_valid, 1 wr_due, 2 auto_pre)
    task automatic measure(input int sel, input int exp, input string req);
        int n;
        bit s;
        n = 1;
        forever begin
            #1;
            s = (sel == 0) ? rd_valid : (sel == 1) ? wr_due : auto_pre;
            if (s || n > 60) break;
            @(negedge clk);
            n++;
        end
        check(n == exp, req, n, exp);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; cfg_load = 1'b0;
        {cfg_rcd_rd, cfg_rcd_wr, cfg_ras, cfg_rp, cfg_cl, cfg_cwl} = '0;
        set_req(1'b0, 0, 0, 1'b0);
        idle(3);
        rst = 1'b0;
        #1;
        check(bank_open == 1'b0, "R1 bank closed", int'(bank_open), 0);
        check(grant == 1'b0, "R1 grant low", int'(grant), 0);
        check(rd_valid == 1'b0 && wr_due == 1'b0 && auto_pre == 1'b0,
              "R1 pulses low", int'(rd_valid | wr_due | auto_pre), 0);
    endtask

    task automatic t_open_read;
        int cnt, first;
        issue(0, 5, 1'b0, 1, "R1 open at once after reset");
        #1;
        check(bank_open == 1'b1, "R2 bank open", int'(bank_open), 1);
        check(open_row == 5, "R2 open row", int'(open_row), 5);
        issue(1, 5, 1'b0, 4, "R3 R9 read waits rcd_rd");
        measure(0, 5, "R4 read latency");
        for (int i = 0; i < 3; i++) begin
            set_req(1'b1, 1, 5, 1'b0);
            #1;
            check(grant == 1'b1, "R4 back-to-back read grant", int'(grant), 1);
            @(negedge clk);
        end
        set_req(1'b0, 0, 0, 1'b0);
        cnt = 0; first = 0;
        for (int k = 1; k <= 12; k++) begin
            #1;
            if (rd_valid) begin
                cnt++;
                if (first == 0) first = k;
            end
            @(negedge clk);
        end
        check(cnt == 3, "R4 pulse count", cnt, 3);
        check(first == 3, "R4 first pulse", first, 3);
    endtask

    task automatic t_write_miss;
        bit seen;
        issue(2, 5, 1'b0, 1, "R3 write on long-open row");
        measure(1, 3, "R5 write latency");
        set_req(1'b1, 1, 9, 1'b0);
        seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            #1;
            if (grant || row_hit) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, "R6 other row not granted", int'(seen), 0);
        set_req(1'b1, 1, 5, 1'b0);
        #1;
        check(row_hit == 1'b1, "R6 hit on open row", int'(row_hit), 1);
        @(negedge clk);
        set_req(1'b0, 0, 0, 1'b0);
    endtask

    task automatic t_pre_act;
        bit seen;
        idle(6);
        issue(3, 0, 1'b0, 1, "R7 close after ras elapsed");
        #1;
        check(bank_open == 1'b0, "R7 bank closed", int'(bank_open), 0);
        issue(0, 7, 1'b0, 3, "R8 open waits rp");
        issue(3, 0, 1'b0, 8, "R7 R9 close waits ras");
        set_req(1'b1, 1, 7, 1'b0);
        seen = 1'b0;
        for (int i = 0; i < 4; i++) begin
            #1;
            if (grant) seen = 1'b1;
            @(negedge clk);
        end
        set_req(1'b0, 0, 0, 1'b0);
        check(!seen, "R6 read to closed bank not granted", int'(seen), 0);
    endtask

    task automatic t_wr_rcd;
        idle(10);
        issue(0, 2, 1'b0, 1, "R2 open row 2");
        issue(2, 2, 1'b0, 2, "R3 write waits rcd_wr");
        issue(1, 2, 1'b0, 2, "R3 read still waits rcd_rd");
    endtask

    task automatic t_auto;
        idle(10);
        issue(3, 0, 1'b0, 1, "R7 close before auto test");
        idle(5);
        issue(0, 4, 1'b0, 1, "R2 open row 4");
        issue(1, 4, 1'b1, 4, "R10 read with close flag");
        measure(2, 4, "R10 auto close cycle");
        #1;
        check(bank_open == 1'b0, "R10 bank closed after auto", int'(bank_open), 0);
        issue(0, 4, 1'b0, 3, "R10 R8 open waits rp after auto");
    endtask

    task automatic t_pre_closed;
        idle(10);
        issue(3, 0, 1'b0, 1, "R7 close open bank");
        idle(10);
        issue(3, 0, 1'b0, 1, "R12 close on closed bank");
        issue(0, 3, 1'b0, 1, "R12 open not delayed");
        #1;
        check(bank_open == 1'b1, "R12 bank open", int'(bank_open), 1);
    endtask

    task automatic t_cfg;
        // bank opened one cycle before this load attempt
        cfg_load = 1'b1;
        cfg_rcd_rd = 5'd0; cfg_rcd_wr = 5'd0; cfg_ras = 5'd2;
        cfg_rp = 5'd0; cfg_cl = 5'd0; cfg_cwl = 5'd6;
        @(negedge clk);
        cfg_load = 1'b0;
        issue(3, 0, 1'b0, 7, "R11 load ignored while open");
        idle(40);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        issue(0, 1, 1'b0, 1, "R11 open after load");
        issue(1, 1, 1'b0, 1, "R11 zero rcd_rd acts as one");
        measure(0, 1, "R11 zero cl acts as one");
        issue(2, 1, 1'b0, 1, "R11 zero rcd_wr acts as one");
        measure(1, 6, "R11 loaded cwl");
    endtask

    initial begin
        t_reset();
        t_open_read();
        t_write_miss();
        t_pre_act();
        t_wr_rcd();
        t_auto();
        t_pre_closed();
        t_cfg();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule